// File: doc/BRIEF.md
# Looping Vector Pattern Sequencer

This block walks a local pattern memory and hands its vector words, one per handshake, to the pin formatters. The memory also holds a compact control code: loops that run a set number of times, loops that run until told to stop, branches that fire when the compare logic reports a parallel match or when a serial capture register matches a masked pattern, a pause that waits for a software trigger, and a halt. Once started, it runs on its own with no host involvement.

Each memory word is 13 bits wide with the default parameters. Bits [12:11] hold the opcode. The other fields are described in the requirements below. Every issued vector carries its own timing-set select, so the timing set can change from one vector to the next. A host port lets software patch any word while a pattern runs. A patch takes effect the next time the sequencer fetches that address.

Vectors leave on a valid/ready stream. `vec_valid` rises with a payload and stays high, with the payload unchanged, until `vec_ready` is seen high on a clock edge. The sequencer stalls for as long as `vec_ready` is low. Host writes use their own valid/ready pair. The host must hold `hw_valid`, `hw_addr` and `hw_data` steady until `hw_ready` is high on an edge. `hw_ready` depends combinationally on `vec_ready` and on the sequencer's fetch in the same cycle.

Top module: `patseq_engine`

## Requirements
- R1: During and after reset, `vec_valid`, `busy`, `done` and `hold_active` are low, and `hw_ready` is high.
- R2: A `start` pulse while idle or done begins execution at address 0, and vector words are issued in address order. A vector word has opcode 00 and lays out its payload as follows:
  - bits [10:9] are the timing select;
  - bit [8] is the compare enable;
  - bits [7:0] are the drive data.
  The three fields appear on `vec_tsel`, `vec_cmp` and `vec_drive`, and `cmp_enable` carries the compare enable of the last accepted vector.
- R3: While `vec_valid` is high and `vec_ready` is low, `vec_valid` stays high on the next cycle and the payload does not change. Each handshake moves exactly one vector.
- R4: Opcode 01 opens a loop whose count N is in bits [7:0]. For N>0 the body, which runs up to the matching loop end, executes N times. Loops nest two deep.
- R5: A loop opened with N=0 repeats until `stop`. A pulse on `stop` is remembered. It ends whichever loop is innermost at the next loop end, and execution then continues after that loop end.
- R6: Opcode 10 is a control word. Its subcode in bits [10:9] selects the action, and its target is in bits [5:0]:
  - 00 is a loop end;
  - 01 jumps to the target if `par_match` is high;
  - 10 jumps to the target on a serial match;
  - 11 halts, after which `done` goes high and `busy` goes low.
- R7: Each accepted vector shifts `ser_bit` into a 16-bit register at the LSB, and that register is cleared by `start`. A serial match means that `(reg ^ ser_pattern) & ser_mask` is zero.
- R8: Opcode 11 pauses the sequencer. While paused, `hold_active` is high, `vec_valid` and `cmp_enable` are low, and `hold_data` keeps the drive data of the last accepted vector. A `sw_trig` pulse during the pause resumes execution at the next word.
- R9: A host write accepted while a pattern runs is seen at the next fetch of that address.
- R10: If a host write and a fetch target the same address in the same cycle, the fetch wins. `hw_ready` is low in that cycle, and the write completes on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at address 0 |
| stop | input | 1 | Pulse: end the innermost loop at its next loop end |
| sw_trig | input | 1 | Software trigger that releases a pause |
| par_match | input | 1 | Parallel compare match from the compare logic |
| ser_bit | input | 1 | Compare result of the serial pin |
| ser_pattern | input | SER_W | Serial match pattern |
| ser_mask | input | SER_W | Serial match bit mask |
| busy | output | 1 | Executing or paused |
| done | output | 1 | Halt reached |
| vec_valid | output | 1 | Vector payload is valid |
| vec_ready | input | 1 | Formatter accepts the vector |
| vec_drive | output | PINS | Drive data |
| vec_cmp | output | 1 | Compare enable of the vector |
| vec_tsel | output | TSEL_W | Timing-set select |
| hold_active | output | 1 | Paused on a trigger wait |
| hold_data | output | PINS | Drive data of the last accepted vector |
| cmp_enable | output | 1 | Compare enable in force; low while paused |
| hw_valid | input | 1 | Host write request |
| hw_ready | output | 1 | Host write accepted this cycle |
| hw_addr | input | ADDR_W | Host write address |
| hw_data | input | TSEL_W+PINS+3 | Host write word |

## Verification
Wrong internal state here shows up as a wrong or missing vector in the output stream:
- A loop counter that is off by one adds or drops one whole body pass. The scoreboard sees this at the first vector after the loop.
- A stale serial register or a wrong branch decode sends execution down the other arm. This shows at the first vector after the branch.
- A collision resolved the wrong way is seen two ways: `hw_ready` is high in the cycle of the fetch, and the patched vector appears one loop pass early.
- A pause that leaks drive or compare state shows on `hold_data` or `cmp_enable` during the pause itself.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
  typedef enum logic [1:0] {
    OP_VEC  = 2'b00,
    OP_LOOP = 2'b01,
    OP_CTRL = 2'b10,
    OP_WAIT = 2'b11
  } op_t;

  typedef enum logic [1:0] {
    CT_LOOP_END = 2'b00,
    CT_BR_PAR   = 2'b01,
    CT_BR_SER   = 2'b10,
    CT_HALT     = 2'b11
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_HOLD,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/patseq_pattern_mem.sv
module patseq_pattern_mem #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem_q[rd_addr];
  end
endmodule

// File: rtl/patseq_loop_stack.sv
module patseq_loop_stack #(
  parameter int NEST   = 2,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic              dec,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [CNT_W-1:0]  push_cnt,
  input  logic              push_endless,
  output logic [ADDR_W-1:0] top_addr,
  output logic [CNT_W-1:0]  top_cnt,
  output logic              top_endless,
  output logic              empty
);
  localparam int SP_W = $clog2(NEST + 1);

  logic [SP_W-1:0]             sp_q;
  logic [NEST-1:0][ADDR_W-1:0] addr_v;
  logic [NEST-1:0][CNT_W-1:0]  cnt_v;
  logic [NEST-1:0]             endless_v;
  logic                        full;

  assign full  = (sp_q == SP_W'(NEST));
  assign empty = (sp_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sp_q <= '0;
    else if (clear)          sp_q <= '0;
    else if (push && !full)  sp_q <= sp_q + 1'b1;
    else if (pop && !empty)  sp_q <= sp_q - 1'b1;
  end

  for (genvar i = 0; i < NEST; i++) begin : g_ent
    logic [ADDR_W-1:0] a_q;
    logic [CNT_W-1:0]  c_q;
    logic              e_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        c_q <= '0;
        e_q <= 1'b0;
      end else if (push && sp_q == SP_W'(i)) begin
        a_q <= push_addr;
        c_q <= push_cnt;
        e_q <= push_endless;
      end else if (dec && sp_q == SP_W'(i + 1)) begin
        c_q <= c_q - 1'b1;
      end
    end

    assign addr_v[i]    = a_q;
    assign cnt_v[i]     = c_q;
    assign endless_v[i] = e_q;
  end

  always_comb begin
    top_addr    = '0;
    top_cnt     = '0;
    top_endless = 1'b0;
    for (int i = 0; i < NEST; i++) begin
      if (sp_q == SP_W'(i + 1)) begin
        top_addr    = addr_v[i];
        top_cnt     = cnt_v[i];
        top_endless = endless_v[i];
      end
    end
  end
endmodule

// File: rtl/patseq_serial_match.sv
module patseq_serial_match #(
  parameter int SER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             bit_in,
  input  logic [SER_W-1:0] pattern,
  input  logic [SER_W-1:0] mask,
  output logic             hit
);
  logic [SER_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (clear) sr_q <= '0;
    else if (shift) sr_q <= {sr_q[SER_W-2:0], bit_in};
  end

  assign hit = (((sr_q ^ pattern) & mask) == '0);
endmodule

// File: rtl/patseq_engine.sv
module patseq_engine
  import patseq_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int TSEL_W = 2,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int SER_W  = 16,
  parameter int NEST   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   stop,
  input  logic                   sw_trig,
  input  logic                   par_match,
  input  logic                   ser_bit,
  input  logic [SER_W-1:0]       ser_pattern,
  input  logic [SER_W-1:0]       ser_mask,
  output logic                   busy,
  output logic                   done,
  output logic                   vec_valid,
  input  logic                   vec_ready,
  output logic [PINS-1:0]        vec_drive,
  output logic                   vec_cmp,
  output logic [TSEL_W-1:0]      vec_tsel,
  output logic                   hold_active,
  output logic [PINS-1:0]        hold_data,
  output logic                   cmp_enable,
  input  logic                   hw_valid,
  output logic                   hw_ready,
  input  logic [ADDR_W-1:0]      hw_addr,
  input  logic [TSEL_W+PINS+2:0] hw_data
);
  localparam int PAY_W  = TSEL_W + 1 + PINS;
  localparam int WORD_W = PAY_W + 2;

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, nxt_pc;
  logic [WORD_W-1:0] word;
  logic              fetch;
  logic              stop_q, stop_clr;
  logic              st_push, st_pop, st_dec, st_empty, st_top_endless;
  logic [ADDR_W-1:0] st_top_addr;
  logic [CNT_W-1:0]  st_top_cnt, operand;
  logic              ser_hit, begin_run, vec_take;
  logic [PINS-1:0]   hold_data_q;
  logic              last_cmp_q;
  op_t               op;
  ctrl_t             sub;

  assign op        = op_t'(word[WORD_W-1 -: 2]);
  assign sub       = ctrl_t'(word[PAY_W-1 -: 2]);
  assign operand   = word[CNT_W-1:0];
  assign vec_drive = word[PINS-1:0];
  assign vec_cmp   = word[PINS];
  assign vec_tsel  = word[PAY_W-1 -: TSEL_W];
  assign begin_run = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign vec_take  = vec_valid && vec_ready;

  always_comb begin
    state_d   = state_q;
    nxt_pc    = pc_q + 1'b1;
    fetch     = 1'b0;
    vec_valid = 1'b0;
    st_push   = 1'b0;
    st_pop    = 1'b0;
    st_dec    = 1'b0;
    stop_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          fetch   = 1'b1;
          nxt_pc  = '0;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        unique case (op)
          OP_VEC: begin
            vec_valid = 1'b1;
            fetch     = vec_ready;
          end
          OP_LOOP: begin
            st_push = 1'b1;
            fetch   = 1'b1;
          end
          OP_CTRL: begin
            unique case (sub)
              CT_LOOP_END: begin
                fetch = 1'b1;
                if (!st_empty) begin
                  if (stop_q || (!st_top_endless && st_top_cnt == '0)) begin
                    st_pop   = 1'b1;
                    stop_clr = stop_q;
                  end else begin
                    nxt_pc = st_top_addr;
                    st_dec = !st_top_endless;
                  end
                end
              end
              CT_BR_PAR: begin
                fetch = 1'b1;
                if (par_match) nxt_pc = word[ADDR_W-1:0];
              end
              CT_BR_SER: begin
                fetch = 1'b1;
                if (ser_hit) nxt_pc = word[ADDR_W-1:0];
              end
              CT_HALT: state_d = ST_DONE;
            endcase
          end
          OP_WAIT: state_d = ST_HOLD;
        endcase
      end
      ST_HOLD: begin
        if (sw_trig) begin
          fetch   = 1'b1;
          state_d = ST_EXEC;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      if (fetch) pc_q <= nxt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stop_q <= 1'b0;
    else if (begin_run) stop_q <= 1'b0;
    else                stop_q <= (stop_q && !stop_clr) || stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data_q <= '0;
      last_cmp_q  <= 1'b0;
    end else if (vec_take) begin
      hold_data_q <= vec_drive;
      last_cmp_q  <= vec_cmp;
    end
  end

  assign hold_active = (state_q == ST_HOLD);
  assign hold_data   = hold_data_q;
  assign cmp_enable  = last_cmp_q && !hold_active;
  assign busy        = (state_q == ST_EXEC) || hold_active;
  assign done        = (state_q == ST_DONE);
  assign hw_ready    = !(fetch && hw_addr == nxt_pc);

  patseq_pattern_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .rd_en   (fetch),
    .rd_addr (nxt_pc),
    .rd_data (word),
    .wr_en   (hw_valid && hw_ready),
    .wr_addr (hw_addr),
    .wr_data (hw_data)
  );

  patseq_loop_stack #(.NEST(NEST), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stack (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (begin_run),
    .push         (st_push),
    .pop          (st_pop),
    .dec          (st_dec),
    .push_addr    (pc_q + 1'b1),
    .push_cnt     (operand - 1'b1),
    .push_endless (operand == '0),
    .top_addr     (st_top_addr),
    .top_cnt      (st_top_cnt),
    .top_endless  (st_top_endless),
    .empty        (st_empty)
  );

  patseq_serial_match #(.SER_W(SER_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (begin_run),
    .shift   (vec_take),
    .bit_in  (ser_bit),
    .pattern (ser_pattern),
    .mask    (ser_mask),
    .hit     (ser_hit)
  );
endmodule

// File: rtl/patseq_engine_chk.sv
module patseq_engine_chk #(
  parameter int PINS   = 8,
  parameter int TSEL_W = 2,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [PINS-1:0]   vec_drive,
  input logic              vec_cmp,
  input logic [TSEL_W-1:0] vec_tsel,
  input logic              hold_active,
  input logic [PINS-1:0]   hold_data,
  input logic              cmp_enable,
  input logic              busy,
  input logic              done,
  input logic              hw_valid,
  input logic              hw_ready,
  input logic [ADDR_W-1:0] hw_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr
);
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable({vec_tsel, vec_cmp, vec_drive})); // R3

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !vec_valid && !cmp_enable); // R8

  AST_HOLD_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active && $past(hold_active) |-> $stable(hold_data)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !vec_valid); // R6

  AST_FETCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid && hw_ready |-> !(rd_en && rd_addr == hw_addr)); // R10
endmodule

bind patseq_engine patseq_engine_chk #(.PINS(PINS), .TSEL_W(TSEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vec_valid   (vec_valid),
  .vec_ready   (vec_ready),
  .vec_drive   (vec_drive),
  .vec_cmp     (vec_cmp),
  .vec_tsel    (vec_tsel),
  .hold_active (hold_active),
  .hold_data   (hold_data),
  .cmp_enable  (cmp_enable),
  .busy        (busy),
  .done        (done),
  .hw_valid    (hw_valid),
  .hw_ready    (hw_ready),
  .hw_addr     (hw_addr),
  .rd_en       (fetch),
  .rd_addr     (nxt_pc)
);

// File: tb/patseq_engine_bench.sv
module patseq_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, sw_trig = 1'b0;
  logic        par_match = 1'b0, ser_bit = 1'b0;
  logic [15:0] ser_pattern = '0, ser_mask = '0;
  logic        busy, done, vec_valid, vec_ready, vec_cmp;
  logic [7:0]  vec_drive, hold_data;
  logic [1:0]  vec_tsel;
  logic        hold_active, cmp_enable;
  logic        hw_valid = 1'b0, hw_ready;
  logic [5:0]  hw_addr = '0;
  logic [12:0] hw_data = '0;

  int          checks = 0, errors = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  int          ready_mode = 0;
  logic        ready_man = 1'b0;
  int          cyc = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #1 cyc <= cyc + 1;
  end
  assign vec_ready = (ready_mode == 2) ? ready_man :
                     (ready_mode == 1) ? (cyc % 3 != 0) : 1'b1;

  patseq_engine u_patseq_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .sw_trig(sw_trig),
    .par_match(par_match), .ser_bit(ser_bit), .ser_pattern(ser_pattern), .ser_mask(ser_mask),
    .busy(busy), .done(done), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_drive(vec_drive), .vec_cmp(vec_cmp), .vec_tsel(vec_tsel),
    .hold_active(hold_active), .hold_data(hold_data), .cmp_enable(cmp_enable),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_addr(hw_addr), .hw_data(hw_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vec_valid && vec_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 actual=%0h expected=none", {vec_tsel, vec_cmp, vec_drive});
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({vec_tsel, vec_cmp, vec_drive} !== e) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", t, {vec_tsel, vec_cmp, vec_drive}, e);
        end
      end
    end
  end

  task automatic expect_vec(logic [10:0] p, string t);
    exp_q.push_back(p);
    tag_q.push_back(t);
  endtask

  function automatic logic [12:0] w_vec(logic [10:0] p); return {2'b00, p}; endfunction
  function automatic logic [12:0] w_loop(logic [7:0] n); return {2'b01, 3'b000, n}; endfunction
  function automatic logic [12:0] w_end(); return {2'b10, 2'b00, 9'd0}; endfunction
  function automatic logic [12:0] w_br(logic [1:0] s, logic [5:0] t); return {2'b10, s, 3'b000, t}; endfunction
  function automatic logic [12:0] w_halt(); return {2'b10, 2'b11, 9'd0}; endfunction
  function automatic logic [12:0] w_wait(); return {2'b11, 11'd0}; endfunction

  task automatic hwrite(logic [5:0] a, logic [12:0] d);
    @(posedge clk); #1;
    hw_valid = 1'b1; hw_addr = a; hw_data = d;
    do @(negedge clk); while (!hw_ready);
    @(posedge clk); #1 hw_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 4000);
    chk({req, " done"}, {31'd0, done}, 32'd1);
    chk({req, " all vectors issued"}, exp_q.size(), 32'd0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic take_one();
    @(posedge clk); #1 ready_man = 1'b1;
    do @(negedge clk); while (!vec_valid);
    @(posedge clk); #1 ready_man = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vec_valid", {31'd0, vec_valid}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 hold_active", {31'd0, hold_active}, 0);
    chk("R1 hw_ready", {31'd0, hw_ready}, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, busy, vec_valid}, 0);

    // R2 R3 R4: nested counted loops under back-pressure
    hwrite(0, w_loop(2)); hwrite(1, w_loop(3)); hwrite(2, w_vec(11'h1A1));
    hwrite(3, w_end());   hwrite(4, w_vec(11'h2B2)); hwrite(5, w_end());
    hwrite(6, w_vec(11'h7C3)); hwrite(7, w_halt());
    for (int o = 0; o < 2; o++) begin
      for (int i = 0; i < 3; i++) expect_vec(11'h1A1, "R4 inner body");
      expect_vec(11'h2B2, "R4 outer body");
    end
    expect_vec(11'h7C3, "R2 tail");
    ready_mode = 1;
    pulse_start();
    wait_done("R4");
    chk("R6 busy low at halt", {31'd0, busy}, 0);
    chk("R2 cmp_enable of last vector", {31'd0, cmp_enable}, 1);
    ready_mode = 0;

    // R6 parallel branch, taken and not taken
    hwrite(0, w_vec(11'h011)); hwrite(1, w_br(2'b01, 6'd4)); hwrite(2, w_vec(11'h022));
    hwrite(3, w_halt()); hwrite(4, w_vec(11'h033)); hwrite(5, w_halt());
    par_match = 1'b1;
    expect_vec(11'h011, "R2 first"); expect_vec(11'h033, "R6 par taken");
    pulse_start(); wait_done("R6 taken");
    par_match = 1'b0;
    expect_vec(11'h011, "R2 first"); expect_vec(11'h022, "R6 par not taken");
    pulse_start(); wait_done("R6 not taken");

    // R7 serial match
    for (int i = 0; i < 4; i++) hwrite(6'(i), w_vec(11'(8'h40 + i)));
    hwrite(4, w_br(2'b10, 6'd7)); hwrite(5, w_vec(11'h555)); hwrite(6, w_halt());
    hwrite(7, w_vec(11'h666)); hwrite(8, w_halt());
    ser_pattern = 16'h000F; ser_mask = 16'h000F; ser_bit = 1'b1;
    for (int i = 0; i < 4; i++) expect_vec(11'(8'h40 + i), "R2 order");
    expect_vec(11'h666, "R7 serial hit");
    pulse_start(); wait_done("R7 hit");
    ser_pattern = 16'h001F; ser_mask = 16'h001F;
    for (int i = 0; i < 4; i++) expect_vec(11'(8'h40 + i), "R2 order");
    expect_vec(11'h555, "R7 cleared at start, miss");
    pulse_start(); wait_done("R7 clear");
    ser_pattern = 16'h000F; ser_mask = 16'h000F; ser_bit = 1'b0;
    for (int i = 0; i < 4; i++) expect_vec(11'(8'h40 + i), "R2 order");
    expect_vec(11'h555, "R7 serial miss");
    pulse_start(); wait_done("R7 miss");

    // R8 pause until software trigger
    hwrite(0, w_vec(11'h1A5)); hwrite(1, w_wait()); hwrite(2, w_vec(11'h05A)); hwrite(3, w_halt());
    expect_vec(11'h1A5, "R8 before pause");
    expect_vec(11'h05A, "R8 resumes at next word");
    pulse_start();
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!hold_active && n < 100);
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R8 hold_active", {31'd0, hold_active}, 1);
      chk("R8 no vector", {31'd0, vec_valid}, 0);
      chk("R8 hold_data", {24'd0, hold_data}, 32'hA5);
      chk("R8 compare off", {31'd0, cmp_enable}, 0);
    end
    @(posedge clk); #1 sw_trig = 1'b1;
    @(posedge clk); #1 sw_trig = 1'b0;
    wait_done("R8");

    // R5 endless loop ended by stop
    hwrite(0, w_loop(0)); hwrite(1, w_vec(11'h0AA)); hwrite(2, w_vec(11'h0BB));
    hwrite(3, w_end());   hwrite(4, w_vec(11'h0CC)); hwrite(5, w_halt());
    for (int i = 0; i < 4; i++) begin
      expect_vec(11'h0AA, "R5 endless body"); expect_vec(11'h0BB, "R5 endless body");
    end
    expect_vec(11'h0CC, "R5 exit after stop");
    ready_mode = 2;
    pulse_start();
    for (int i = 0; i < 7; i++) take_one();
    @(posedge clk); #1 stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
    ready_mode = 0;
    wait_done("R5");

    // R9 R10 host patch with fetch collision
    hwrite(0, w_loop(2)); hwrite(1, w_vec(11'h111)); hwrite(2, w_vec(11'h222));
    hwrite(3, w_end());   hwrite(4, w_halt());
    expect_vec(11'h111, "R9 pass 1"); expect_vec(11'h222, "R10 fetch read old word");
    expect_vec(11'h111, "R9 pass 2"); expect_vec(11'h3EE, "R9 patched word");
    ready_mode = 2; ready_man = 1'b0;
    pulse_start();
    do @(negedge clk); while (!vec_valid);
    @(posedge clk); #1;
    ready_man = 1'b1; hw_valid = 1'b1; hw_addr = 6'd2; hw_data = w_vec(11'h3EE);
    @(negedge clk);
    chk("R10 hw_ready low on collision", {31'd0, hw_ready}, 0);
    @(posedge clk); #1 ready_man = 1'b0;
    @(negedge clk);
    chk("R10 retry accepted", {31'd0, hw_ready}, 1);
    @(posedge clk); #1 hw_valid = 1'b0;
    ready_mode = 0;
    wait_done("R9");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule